// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks outstanding line misses for a data cache that keeps serving requests while misses are in flight. A miss whose line is not yet tracked takes the lowest-numbered free register and raises a one-cycle memory request that carries the line address and the register number. A miss to a line that is already tracked is appended as another target to that register, and no second request goes out. Each target is a load, identified by its destination tag and word offset, or a store, identified by its word offset, byte enables and data.

When memory answers with the register number and the full line, the block overlays every pending store onto the returned data in the order the stores were recorded. One cycle later it presents the merged line as the cache write. From the following cycle on, it emits one completion per pending load on the result bus, one per cycle, and it frees the register together with the last load. If the block cannot take a miss, it raises a stall in the same cycle and the requester retries.

Top module: `mshr_file`

## Requirements
- R1: After reset, all registers are free and miss_stall, mem_req_valid, fill_valid and cdb_valid are low.
- R2: A miss to an untracked line, when a register is free, raises mem_req_valid in the same cycle with mem_req_line equal to the miss line and mem_req_id equal to the lowest-numbered free register.
- R3: A miss to a line held by a waiting register with a free target slot is recorded as a new target, with mem_req_valid and miss_stall both low. This holds even when every register is busy.
- R4: When all NUM_ENTRIES registers are busy, a miss to an untracked line raises miss_stall and issues no request.
- R5: When the matching register already holds NUM_TARGETS targets, a further miss to that line raises miss_stall and issues no request.
- R6: A response accepted at a clock edge produces fill_valid for exactly one cycle after that edge. fill_line is the register's line and fill_data is the returned line with stores merged in. Store word k occupies bits [32k+31:32k], and byte b of that word is written where miss_be[b] is 1.
- R7: Stores are merged in the order they were recorded, so the later store wins on overlapping bytes.
- R8: Load completions start in the cycle after fill_valid and come one per cycle, in the order the loads were recorded. cdb_tag is the load's tag and cdb_data is the merged word at the load's offset. No completion appears beyond the number of loads.
- R9: A register is free again in the cycle after its last load completion, and a new miss to the same line then allocates it afresh with a new request.
- R10: A miss to a tracked line raises miss_stall and issues no request in two cases: the response for that register arrives in the same cycle, or the register is already delivering its completions.
- R11: Misses to other lines are accepted and allocated while a register is delivering completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A cache miss is presented this cycle |
| miss_line | input | LINE_ADDR_W | Line address of the miss |
| miss_is_store | input | 1 | 1 for a store target, 0 for a load target |
| miss_tag | input | TAG_W | Destination tag of a load |
| miss_ofs | input | OFS_W | Word offset within the line |
| miss_wdata | input | WORD_W | Store data |
| miss_be | input | WORD_W/8 | Store byte enables |
| miss_stall | output | 1 | Miss not taken; retry |
| mem_req_valid | output | 1 | Memory request for a new line |
| mem_req_line | output | LINE_ADDR_W | Line address requested |
| mem_req_id | output | ID_W | Register number the response must carry |
| mem_resp_valid | input | 1 | Memory response present |
| mem_resp_id | input | ID_W | Register number of the response |
| mem_resp_data | input | LINE_W | Returned line |
| fill_valid | output | 1 | Cache write of a completed line |
| fill_line | output | LINE_ADDR_W | Line address to write |
| fill_data | output | LINE_W | Line with stores merged |
| cdb_valid | output | 1 | One load completion |
| cdb_tag | output | TAG_W | Tag of the completing load |
| cdb_data | output | WORD_W | Loaded word |

## Verification
Two functions can land in one cycle: a response arriving for a register and a secondary miss trying to join that same register. The bench raises both in one cycle, expects miss_stall high with no request, and then checks that the merged fill contains only the stores recorded before the response. It also presents a miss to the same line while the register is delivering completions, expecting a stall. In the next cycle it presents a miss to another line, expecting a fresh allocation while the completions carry on without a gap.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRAIN = 2'd2
  } mshr_state_e;
endpackage

// File: rtl/mshr_pick.sv
// Lowest-index priority picker.
module mshr_pick #(
  parameter int N     = 11,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/mshr_entry.sv
// One miss register: line address, ordered targets, line buffer.
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int LINE_ADDR_W = 26,
  parameter int NUM_TARGETS = 4,
  parameter int TAG_W       = 6,
  parameter int WORD_W      = 32,
  parameter int LINE_W      = 128,
  parameter int OFS_W       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_en,
  input  logic                   merge_en,
  input  logic                   resp_en,
  input  logic                   drain_en,
  input  logic [LINE_ADDR_W-1:0] req_line,
  input  logic                   req_is_store,
  input  logic [TAG_W-1:0]       req_tag,
  input  logic [OFS_W-1:0]       req_ofs,
  input  logic [WORD_W-1:0]      req_wdata,
  input  logic [WORD_W/8-1:0]    req_be,
  input  logic [LINE_W-1:0]      resp_data,
  output mshr_state_e            state_o,
  output logic [LINE_ADDR_W-1:0] line_o,
  output logic                   full_o,
  output logic [LINE_W-1:0]      merged_o,
  output logic                   has_load_o,
  output logic [TAG_W-1:0]       load_tag_o,
  output logic [WORD_W-1:0]      load_word_o
);
  localparam int BE_W   = WORD_W / 8;
  localparam int CNT_W  = $clog2(NUM_TARGETS + 1);
  localparam int SLOT_W = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1;

  mshr_state_e            state_q, state_d;
  logic [LINE_ADDR_W-1:0] line_q, line_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [NUM_TARGETS-1:0] vld_q, vld_d;
  logic [NUM_TARGETS-1:0] st_q, st_d;
  logic [NUM_TARGETS-1:0] slot_we;
  logic [NUM_TARGETS-1:0] clear;
  logic [TAG_W-1:0]       tag_q  [NUM_TARGETS];
  logic [OFS_W-1:0]       ofs_q  [NUM_TARGETS];
  logic [WORD_W-1:0]      data_q [NUM_TARGETS];
  logic [BE_W-1:0]        be_q   [NUM_TARGETS];
  logic [LINE_W-1:0]      buf_q;
  logic [SLOT_W-1:0]      sel;
  logic                   found;

  // Stores applied in slot order: later slots overwrite earlier ones.
  always_comb begin
    merged_o = resp_data;
    for (int i = 0; i < NUM_TARGETS; i++) begin
      for (int b = 0; b < BE_W; b++) begin
        if (vld_q[i] && st_q[i] && be_q[i][b])
          merged_o[ofs_q[i]*WORD_W + b*8 +: 8] = data_q[i][b*8 +: 8];
      end
    end
  end

  // Oldest pending load.
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_TARGETS; i++) begin
      if (!found && vld_q[i] && !st_q[i]) begin
        sel   = SLOT_W'(i);
        found = 1'b1;
      end
    end
  end

  assign has_load_o  = (state_q == ST_DRAIN) && found;
  assign load_tag_o  = tag_q[sel];
  assign load_word_o = buf_q[ofs_q[sel]*WORD_W +: WORD_W];
  assign state_o     = state_q;
  assign line_o      = line_q;
  assign full_o      = (cnt_q == CNT_W'(NUM_TARGETS));

  // Next state.
  always_comb begin
    state_d = state_q;
    line_d  = line_q;
    cnt_d   = cnt_q;
    vld_d   = vld_q;
    st_d    = st_q;
    slot_we = '0;
    clear   = drain_en ? (NUM_TARGETS'(1) << sel) : '0;
    unique case (state_q)
      ST_IDLE: begin
        if (alloc_en) begin
          state_d = ST_WAIT;
          line_d  = req_line;
          cnt_d   = CNT_W'(1);
          vld_d   = NUM_TARGETS'(1);
          slot_we = NUM_TARGETS'(1);
          st_d[0] = req_is_store;
        end
      end
      ST_WAIT: begin
        if (merge_en) begin
          for (int i = 0; i < NUM_TARGETS; i++) begin
            if (cnt_q == CNT_W'(i)) begin
              slot_we[i] = 1'b1;
              vld_d[i]   = 1'b1;
              st_d[i]    = req_is_store;
            end
          end
          cnt_d = cnt_q + CNT_W'(1);
        end
        if (resp_en) begin
          state_d = ST_DRAIN;
          vld_d   = vld_q & ~st_q;
        end
      end
      ST_DRAIN: begin
        vld_d = vld_q & ~clear;
        if ((vld_q & ~st_q & ~clear) == '0) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      cnt_q   <= '0;
      vld_q   <= '0;
      st_q    <= '0;
    end else begin
      state_q <= state_d;
      line_q  <= line_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
      st_q    <= st_d;
    end
  end

  // Payload registers, written only under their enables.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_TARGETS; i++) begin
      if (slot_we[i]) begin
        tag_q[i]  <= req_tag;
        ofs_q[i]  <= req_ofs;
        data_q[i] <= req_wdata;
        be_q[i]   <= req_be;
      end
    end
    if (resp_en) buf_q <= merged_o;
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int NUM_ENTRIES = 11,
  parameter int NUM_TARGETS = 4,
  parameter int LINE_ADDR_W = 26,
  parameter int TAG_W       = 6,
  parameter int WORD_W      = 32,
  parameter int LINE_BYTES  = 16,
  localparam int LINE_W     = LINE_BYTES * 8,
  localparam int OFS_W      = $clog2(LINE_W / WORD_W),
  localparam int ID_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   miss_valid,
  input  logic [LINE_ADDR_W-1:0] miss_line,
  input  logic                   miss_is_store,
  input  logic [TAG_W-1:0]       miss_tag,
  input  logic [OFS_W-1:0]       miss_ofs,
  input  logic [WORD_W-1:0]      miss_wdata,
  input  logic [WORD_W/8-1:0]    miss_be,
  output logic                   miss_stall,
  output logic                   mem_req_valid,
  output logic [LINE_ADDR_W-1:0] mem_req_line,
  output logic [ID_W-1:0]        mem_req_id,
  input  logic                   mem_resp_valid,
  input  logic [ID_W-1:0]        mem_resp_id,
  input  logic [LINE_W-1:0]      mem_resp_data,
  output logic                   fill_valid,
  output logic [LINE_ADDR_W-1:0] fill_line,
  output logic [LINE_W-1:0]      fill_data,
  output logic                   cdb_valid,
  output logic [TAG_W-1:0]       cdb_tag,
  output logic [WORD_W-1:0]      cdb_data
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mshr_state_e            ent_state  [NUM_ENTRIES];
  logic [LINE_ADDR_W-1:0] ent_line   [NUM_ENTRIES];
  logic [LINE_W-1:0]      ent_merged [NUM_ENTRIES];
  logic [TAG_W-1:0]       ent_ltag   [NUM_ENTRIES];
  logic [WORD_W-1:0]      ent_lword  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] ent_full, ent_has_load;
  logic [NUM_ENTRIES-1:0] hit_vec, hit_ok, free_vec, resp_en;
  logic [NUM_ENTRIES-1:0] alloc_en, merge_en, drain_en;
  logic                   any_hit, accept_new;
  logic [ID_W-1:0]        alloc_idx, drain_idx;
  logic                   alloc_any, drain_any;

  // Lookup, allocation and stall.
  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      free_vec[e] = (ent_state[e] == ST_IDLE);
      hit_vec[e]  = !free_vec[e] && (ent_line[e] == miss_line);
      resp_en[e]  = mem_resp_valid && (mem_resp_id == ID_W'(e)) &&
                    (ent_state[e] == ST_WAIT);
      hit_ok[e]   = hit_vec[e] && (ent_state[e] == ST_WAIT) &&
                    !resp_en[e] && !ent_full[e];
    end
    any_hit    = |hit_vec;
    accept_new = miss_valid && !any_hit && alloc_any;
    miss_stall = miss_valid && (any_hit ? !(|hit_ok) : !alloc_any);
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      alloc_en[e] = accept_new && (alloc_idx == ID_W'(e));
      merge_en[e] = miss_valid && hit_ok[e];
      drain_en[e] = drain_any && (drain_idx == ID_W'(e));
    end
  end

  assign mem_req_valid = accept_new;
  assign mem_req_line  = miss_line;
  assign mem_req_id    = alloc_idx;

  mshr_pick #(.N(NUM_ENTRIES), .IDX_W(ID_W)) u_alloc_pick (
    .req(free_vec), .idx(alloc_idx), .any(alloc_any)
  );

  mshr_pick #(.N(NUM_ENTRIES), .IDX_W(ID_W)) u_drain_pick (
    .req(ent_has_load), .idx(drain_idx), .any(drain_any)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    mshr_entry #(
      .LINE_ADDR_W(LINE_ADDR_W), .NUM_TARGETS(NUM_TARGETS), .TAG_W(TAG_W),
      .WORD_W(WORD_W), .LINE_W(LINE_W), .OFS_W(OFS_W)
    ) u_entry (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .alloc_en    (alloc_en[g]),
      .merge_en    (merge_en[g]),
      .resp_en     (resp_en[g]),
      .drain_en    (drain_en[g]),
      .req_line    (miss_line),
      .req_is_store(miss_is_store),
      .req_tag     (miss_tag),
      .req_ofs     (miss_ofs),
      .req_wdata   (miss_wdata),
      .req_be      (miss_be),
      .resp_data   (mem_resp_data),
      .state_o     (ent_state[g]),
      .line_o      (ent_line[g]),
      .full_o      (ent_full[g]),
      .merged_o    (ent_merged[g]),
      .has_load_o  (ent_has_load[g]),
      .load_tag_o  (ent_ltag[g]),
      .load_word_o (ent_lword[g])
    );
  end

  // Output next-state.
  logic                   fill_valid_d, cdb_valid_d;
  logic [LINE_ADDR_W-1:0] fill_line_d;
  logic [LINE_W-1:0]      fill_data_d;
  logic [TAG_W-1:0]       cdb_tag_d;
  logic [WORD_W-1:0]      cdb_data_d;

  always_comb begin
    fill_valid_d = |resp_en;
    fill_line_d  = '0;
    fill_data_d  = '0;
    cdb_valid_d  = drain_any;
    cdb_tag_d    = '0;
    cdb_data_d   = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (resp_en[e]) begin
        fill_line_d = ent_line[e];
        fill_data_d = ent_merged[e];
      end
      if (drain_en[e]) begin
        cdb_tag_d  = ent_ltag[e];
        cdb_data_d = ent_lword[e];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fill_valid <= 1'b0;
      cdb_valid  <= 1'b0;
    end else begin
      fill_valid <= fill_valid_d;
      cdb_valid  <= cdb_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid_d) begin
      fill_line <= fill_line_d;
      fill_data <= fill_data_d;
    end
    if (cdb_valid_d) begin
      cdb_tag  <= cdb_tag_d;
      cdb_data <= cdb_data_d;
    end
  end
endmodule

// File: rtl/mshr_file_checker.sv
module mshr_file_checker #(
  parameter int NUM_ENTRIES = 11,
  parameter int ID_W        = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   miss_valid,
  input logic                   miss_stall,
  input logic                   mem_req_valid,
  input logic [ID_W-1:0]        mem_req_id,
  input logic                   mem_resp_valid,
  input logic                   fill_valid,
  input logic                   cdb_valid,
  input logic                   any_hit,
  input logic                   drain_any,
  input logic [NUM_ENTRIES-1:0] free_vec
);
  assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> free_vec[mem_req_id]);

  assert_no_req_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && any_hit) |-> !mem_req_valid);

  assert_req_not_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !miss_stall);

  assert_fill_after_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $past(mem_resp_valid));

  assert_cdb_from_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> $past(drain_any));
endmodule

bind mshr_file mshr_file_checker #(.NUM_ENTRIES(NUM_ENTRIES), .ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .miss_valid    (miss_valid),
  .miss_stall    (miss_stall),
  .mem_req_valid (mem_req_valid),
  .mem_req_id    (mem_req_id),
  .mem_resp_valid(mem_resp_valid),
  .fill_valid    (fill_valid),
  .cdb_valid     (cdb_valid),
  .any_hit       (any_hit),
  .drain_any     (drain_any),
  .free_vec      (free_vec)
);

// File: tb/mshr_file_bench.sv
`timescale 1ns/1ps
module mshr_file_bench;
  localparam int NE = 11;
  localparam int LA = 26;
  localparam int TW = 6;
  localparam int WW = 32;
  localparam int LW = 128;
  localparam int OW = 2;
  localparam int IW = 4;

  logic          clk, rst_n;
  logic          miss_valid, miss_is_store;
  logic [LA-1:0] miss_line;
  logic [TW-1:0] miss_tag;
  logic [OW-1:0] miss_ofs;
  logic [WW-1:0] miss_wdata;
  logic [3:0]    miss_be;
  logic          miss_stall, mem_req_valid;
  logic [LA-1:0] mem_req_line;
  logic [IW-1:0] mem_req_id;
  logic          mem_resp_valid;
  logic [IW-1:0] mem_resp_id;
  logic [LW-1:0] mem_resp_data;
  logic          fill_valid, cdb_valid;
  logic [LA-1:0] fill_line;
  logic [LW-1:0] fill_data;
  logic [TW-1:0] cdb_tag;
  logic [WW-1:0] cdb_data;

  int checks = 0;
  int fails  = 0;

  localparam logic [LA-1:0] LINE_A = 26'h0000100;
  localparam logic [LA-1:0] LINE_B = 26'h0000200;
  localparam logic [LA-1:0] LINE_X = 26'h3FFFFFF;

  mshr_file u_mshr_file (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_is_store(miss_is_store),
    .miss_tag(miss_tag), .miss_ofs(miss_ofs), .miss_wdata(miss_wdata), .miss_be(miss_be),
    .miss_stall(miss_stall), .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .mem_req_id(mem_req_id), .mem_resp_valid(mem_resp_valid), .mem_resp_id(mem_resp_id),
    .mem_resp_data(mem_resp_data), .fill_valid(fill_valid), .fill_line(fill_line),
    .fill_data(fill_data), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    miss_valid     = 1'b0;
    miss_is_store  = 1'b0;
    miss_line      = '0;
    miss_tag       = '0;
    miss_ofs       = '0;
    miss_wdata     = '0;
    miss_be        = '0;
    mem_resp_valid = 1'b0;
    mem_resp_id    = '0;
    mem_resp_data  = '0;
  endtask

  task automatic put_miss(input logic st, input logic [LA-1:0] line,
                          input logic [TW-1:0] tag, input logic [OW-1:0] ofs,
                          input logic [WW-1:0] data, input logic [3:0] be);
    miss_valid    = 1'b1;
    miss_is_store = st;
    miss_line     = line;
    miss_tag      = tag;
    miss_ofs      = ofs;
    miss_wdata    = data;
    miss_be       = be;
  endtask

  task automatic t_reset();
    quiet();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "miss_stall", LW'(miss_stall), '0);
    chk("R1", "mem_req_valid", LW'(mem_req_valid), '0);
    chk("R1", "fill_valid", LW'(fill_valid), '0);
    chk("R1", "cdb_valid", LW'(cdb_valid), '0);
  endtask

  // Primary miss, three merges, then a full-slot stall.
  task automatic t_merge();
    @(negedge clk);
    put_miss(1'b0, LINE_A, 6'd5, 2'd1, '0, '0); #1;
    chk("R2", "req valid", LW'(mem_req_valid), LW'(1));
    chk("R2", "req line", LW'(mem_req_line), LW'(LINE_A));
    chk("R2", "req id", LW'(mem_req_id), LW'(0));
    chk("R2", "stall", LW'(miss_stall), '0);
    @(negedge clk);
    put_miss(1'b1, LINE_A, '0, 2'd1, 32'hAAAA_1111, 4'b0011); #1;
    chk("R3", "store1 req", LW'(mem_req_valid), '0);
    chk("R3", "store1 stall", LW'(miss_stall), '0);
    @(negedge clk);
    put_miss(1'b1, LINE_A, '0, 2'd1, 32'h0000_0055, 4'b0001); #1;
    chk("R3", "store2 req", LW'(mem_req_valid), '0);
    @(negedge clk);
    put_miss(1'b0, LINE_A, 6'd7, 2'd2, '0, '0); #1;
    chk("R3", "load2 req", LW'(mem_req_valid), '0);
    chk("R3", "load2 stall", LW'(miss_stall), '0);
    @(negedge clk);
    put_miss(1'b0, LINE_A, 6'd9, 2'd0, '0, '0); #1;
    chk("R5", "full slots stall", LW'(miss_stall), LW'(1));
    chk("R5", "full slots req", LW'(mem_req_valid), '0);
  endtask

  // Response with a colliding miss, fill, completions, reuse.
  task automatic t_response();
    logic [LW-1:0] resp, exp_line;
    resp     = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    exp_line = {32'h4444_4444, 32'h3333_3333, 32'h2222_1155, 32'h1111_1111};
    @(negedge clk);
    quiet();
    mem_resp_valid = 1'b1; mem_resp_id = '0; mem_resp_data = resp;
    put_miss(1'b0, LINE_A, 6'd9, 2'd0, '0, '0); #1;
    chk("R10", "stall on resp cycle", LW'(miss_stall), LW'(1));
    chk("R10", "no req on resp cycle", LW'(mem_req_valid), '0);
    @(negedge clk);
    chk("R6", "fill valid", LW'(fill_valid), LW'(1));
    chk("R6", "fill line", LW'(fill_line), LW'(LINE_A));
    chk("R7", "fill data merged", fill_data, exp_line);
    chk("R8", "no cdb with fill", LW'(cdb_valid), '0);
    quiet();
    put_miss(1'b0, LINE_A, 6'd9, 2'd0, '0, '0); #1;
    chk("R10", "stall while draining", LW'(miss_stall), LW'(1));
    chk("R10", "no req while draining", LW'(mem_req_valid), '0);
    @(negedge clk);
    chk("R6", "fill one cycle", LW'(fill_valid), '0);
    chk("R8", "cdb1 valid", LW'(cdb_valid), LW'(1));
    chk("R8", "cdb1 tag", LW'(cdb_tag), LW'(5));
    chk("R8", "cdb1 data", LW'(cdb_data), LW'(32'h2222_1155));
    put_miss(1'b0, LINE_B, 6'd12, 2'd3, '0, '0); #1;
    chk("R11", "other line req", LW'(mem_req_valid), LW'(1));
    chk("R11", "other line id", LW'(mem_req_id), LW'(1));
    @(negedge clk);
    chk("R8", "cdb2 valid", LW'(cdb_valid), LW'(1));
    chk("R8", "cdb2 tag", LW'(cdb_tag), LW'(7));
    chk("R8", "cdb2 data", LW'(cdb_data), LW'(32'h3333_3333));
    quiet();
    @(negedge clk);
    chk("R8", "no extra cdb", LW'(cdb_valid), '0);
    put_miss(1'b0, LINE_A, 6'd3, 2'd0, '0, '0); #1;
    chk("R9", "reuse req", LW'(mem_req_valid), LW'(1));
    chk("R9", "reuse id", LW'(mem_req_id), LW'(0));
  endtask

  // Fill every register, then probe a new and a tracked line.
  task automatic t_full();
    for (int k = 2; k < NE; k++) begin
      @(negedge clk);
      put_miss(1'b0, LA'(32'h300 + k), TW'(k), 2'd0, '0, '0); #1;
      chk("R2", "alloc id", LW'(mem_req_id), LW'(k));
      chk("R2", "alloc req", LW'(mem_req_valid), LW'(1));
    end
    @(negedge clk);
    put_miss(1'b0, LINE_X, 6'd1, 2'd0, '0, '0); #1;
    chk("R4", "all busy stall", LW'(miss_stall), LW'(1));
    chk("R4", "all busy no req", LW'(mem_req_valid), '0);
    @(negedge clk);
    put_miss(1'b1, LINE_B, '0, 2'd2, 32'h1234_5678, 4'hF); #1;
    chk("R3", "merge when all busy", LW'(miss_stall), '0);
    chk("R3", "merge no req", LW'(mem_req_valid), '0);
    @(negedge clk);
    quiet();
  endtask

  initial begin
    t_reset();
    t_merge();
    t_response();
    t_full();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule